// File: doc/BRIEF.md
# L1 Data Port Scheduler with Fill Bypass

This block schedules the one data-array port of a level-1 data cache. Each cycle the port does exactly one kind of work: it either writes a complete 64-byte line delivered by the level-2 cache, or it serves up to two 32-byte load reads from the core. A pending fill always wins the port.

While a fill is being written, one waiting load that targets the arriving line is served by tapping the fill bus. It needs no array read. The other loads are stalled, and the core retries them with the request held stable. Array reads and bypassed loads both answer exactly one cycle after they are granted, so the core sees the same latency on either path.

The data array is a plain register array inside the block. Tags, miss handling, replacement and stores belong to neighbouring logic.

Top module: `l1_port_sched`

## Requirements
- R1: After reset is released, both `rsp_valid_o` bits are 0 until a load is granted.
- R2: A fill is accepted in every cycle it is presented: `fill_ack_o` equals `fill_valid_i` in the same cycle, whatever the loads are doing.
- R3: In a cycle with a fill, no array read takes place, and every load that is not bypassed has its stall bit set.
- R4: In a fill cycle, a bypassed load gets its response one cycle later. The data is the fill data half chosen by address bit 5 of the load: 0 selects bits [255:0] and 1 selects bits [511:256].
- R5: At most one load is bypassed per fill cycle. If both ports are waiting for the filled line, port 0 takes the bypass and port 1 is stalled.
- R6: In a cycle without a fill, every valid load is granted an array read and none is stalled. The response holds the addressed half of the stored line.
- R7: A stall bit is only ever set for a valid load. `ld_stall_o[p]` = 1 means the load was not served this cycle.
- R8: A fill writes the whole line at index `addr[IDX_W+5:6]`. Later loads to either half of that line return the fill data, so a fill followed by both halves finishes in two cycles.
- R9: `rsp_valid_o[p]` is 1 exactly in the cycle after port p is granted, whether by array read or by bypass.
- R10: A load in a fill cycle whose line index differs from the fill's line index is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Line fill present this cycle |
| fill_addr_i | input | ADDR_W | Fill address (line index in bits above 5) |
| fill_data_i | input | 512 | Fill line payload |
| fill_ack_o | output | 1 | Fill written this cycle |
| ld_valid_i | input | 2 | Load request valid, one bit per port |
| ld_addr_i | input | 2 x ADDR_W | Load address per port; bit 5 picks the half |
| ld_stall_o | output | 2 | Load not served this cycle; hold and retry |
| rsp_valid_o | output | 2 | Load response valid per port |
| rsp_data_o | output | 2 x 256 | Load response data per port |

## Verification
The hardest case to reach from the ports is a fill that arrives while both ports are waiting for that same line, one on each half, with the stalled port then served from the array on the very next cycle. Purely random addresses over the whole array rarely line up like this. The stimulus therefore biases the fill's line toward a line that a load is already requesting, holds stalled requests unchanged, and adds directed sequences for both-match, port-1-only-match and no-match fills. Every response is checked against a bench copy of the array, and an assertion checks that no fill cycle also performs an array read.

// File: rtl/l1ps_pkg.sv
package l1ps_pkg;
  localparam int unsigned LINE_W  = 512;
  localparam int unsigned HALF_W  = LINE_W / 2;
  localparam int unsigned OFS_W   = 6;
  localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/l1ps_arb.sv
module l1ps_arb
  import l1ps_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic                            fill_valid_i,
  input  logic [IDX_W-1:0]                fill_idx_i,
  input  logic [N_PORTS-1:0]              ld_valid_i,
  input  logic [N_PORTS-1:0][IDX_W-1:0]   ld_idx_i,
  output logic                            arr_we_o,
  output logic [N_PORTS-1:0]              rd_en_o,
  output logic [N_PORTS-1:0]              byp_o,
  output logic [N_PORTS-1:0]              stall_o
);
  logic taken;

  always_comb begin
    arr_we_o = fill_valid_i;
    taken    = 1'b0;
    for (int p = 0; p < int'(N_PORTS); p++) begin
      rd_en_o[p] = 1'b0;
      byp_o[p]   = 1'b0;
      if (fill_valid_i) begin
        // lowest port wins the single bypass slot
        if (ld_valid_i[p] && (ld_idx_i[p] == fill_idx_i) && !taken) begin
          byp_o[p] = 1'b1;
          taken    = 1'b1;
        end
      end else begin
        rd_en_o[p] = ld_valid_i[p];
      end
      stall_o[p] = ld_valid_i[p] & ~(rd_en_o[p] | byp_o[p]);
    end
  end
endmodule

// File: rtl/l1ps_array.sv
module l1ps_array
  import l1ps_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                            clk_i,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                widx_i,
  input  logic [LINE_W-1:0]               wdata_i,
  input  logic [N_PORTS-1:0][IDX_W-1:0]   ridx_i,
  input  logic [N_PORTS-1:0]              rhalf_i,
  output logic [N_PORTS-1:0][HALF_W-1:0]  rdata_o
);
  logic [LINE_W-1:0] mem_q [NUM_LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
    assign rdata_o[p] = rhalf_i[p] ? mem_q[ridx_i[p]][LINE_W-1:HALF_W]
                                   : mem_q[ridx_i[p]][HALF_W-1:0];
  end
endmodule

// File: rtl/l1ps_rsp.sv
module l1ps_rsp
  import l1ps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              byp_i,
  input  logic [HALF_W-1:0] arr_half_i,
  input  logic [HALF_W-1:0] fill_half_i,
  output logic              rsp_valid_o,
  output logic [HALF_W-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_o <= 1'b0;
    else         rsp_valid_o <= grant_i;
  end

  always_ff @(posedge clk_i) begin
    if (grant_i) rsp_data_o <= byp_i ? fill_half_i : arr_half_i;
  end
endmodule

// File: rtl/l1_port_sched.sv
module l1_port_sched
  import l1ps_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 9
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             fill_valid_i,
  input  logic [ADDR_W-1:0]                fill_addr_i,
  input  logic [LINE_W-1:0]                fill_data_i,
  output logic                             fill_ack_o,
  input  logic [N_PORTS-1:0]               ld_valid_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0]   ld_addr_i,
  output logic [N_PORTS-1:0]               ld_stall_o,
  output logic [N_PORTS-1:0]               rsp_valid_o,
  output logic [N_PORTS-1:0][HALF_W-1:0]   rsp_data_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned HSEL  = OFS_W - 1;

  logic [IDX_W-1:0]               fill_idx;
  logic [N_PORTS-1:0][IDX_W-1:0]  ld_idx;
  logic [N_PORTS-1:0]             ld_half;
  logic                           arr_we;
  logic [N_PORTS-1:0]             arr_rd_en;
  logic [N_PORTS-1:0]             byp_en;
  logic [N_PORTS-1:0][HALF_W-1:0] arr_half;
  logic                           unused_addr_bits;

  assign fill_idx = fill_addr_i[OFS_W +: IDX_W];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
    assign ld_idx[p]  = ld_addr_i[p][OFS_W +: IDX_W];
    assign ld_half[p] = ld_addr_i[p][HSEL];
  end

  assign unused_addr_bits = ^{fill_addr_i, ld_addr_i};

  l1ps_arb #(.IDX_W(IDX_W)) u_arb (
    .fill_valid_i (fill_valid_i),
    .fill_idx_i   (fill_idx),
    .ld_valid_i   (ld_valid_i),
    .ld_idx_i     (ld_idx),
    .arr_we_o     (arr_we),
    .rd_en_o      (arr_rd_en),
    .byp_o        (byp_en),
    .stall_o      (ld_stall_o)
  );

  l1ps_array #(.NUM_LINES(NUM_LINES)) u_array (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .widx_i  (fill_idx),
    .wdata_i (fill_data_i),
    .ridx_i  (ld_idx),
    .rhalf_i (ld_half),
    .rdata_o (arr_half)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rsp
    l1ps_rsp u_rsp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .grant_i     (arr_rd_en[p] | byp_en[p]),
      .byp_i       (byp_en[p]),
      .arr_half_i  (arr_half[p]),
      .fill_half_i (ld_half[p] ? fill_data_i[LINE_W-1:HALF_W] : fill_data_i[HALF_W-1:0]),
      .rsp_valid_o (rsp_valid_o[p]),
      .rsp_data_o  (rsp_data_o[p])
    );
  end

  assign fill_ack_o = arr_we;
endmodule

// File: rtl/l1_port_sched_chk.sv
module l1_port_sched_chk
  import l1ps_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            fill_valid_i,
  input logic [LINE_W-1:0]               fill_data_i,
  input logic                            fill_ack_o,
  input logic [N_PORTS-1:0]              ld_valid_i,
  input logic [N_PORTS-1:0][ADDR_W-1:0]  ld_addr_i,
  input logic [N_PORTS-1:0]              ld_stall_o,
  input logic [N_PORTS-1:0]              rsp_valid_o,
  input logic [N_PORTS-1:0][HALF_W-1:0]  rsp_data_o,
  input logic [N_PORTS-1:0]              arr_rd_en,
  input logic [N_PORTS-1:0]              byp_en
);
  a_r2_fill_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> fill_ack_o);

  a_r3_no_read_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ack_o |-> (arr_rd_en == '0));

  a_r5_single_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(byp_en) <= 1);

  a_r5_bypass_needs_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_en != '0) |-> fill_valid_i);

  a_r6_no_stall_idle_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |-> (ld_stall_o == '0));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    a_r7_stall_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_stall_o[p] |-> ld_valid_i[p]);

    a_r9_rsp_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_valid_i[p] && !ld_stall_o[p]) |=> rsp_valid_o[p]);

    a_r9_no_rsp_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ld_valid_i[p] && !ld_stall_o[p]) |=> !rsp_valid_o[p]);

    a_r4_bypass_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byp_en[p] |=> rsp_data_o[p] == $past(ld_addr_i[p][OFS_W-1] ?
                      fill_data_i[LINE_W-1:HALF_W] : fill_data_i[HALF_W-1:0]));
  end
endmodule

bind l1_port_sched l1_port_sched_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_valid_i (fill_valid_i),
  .fill_data_i  (fill_data_i),
  .fill_ack_o   (fill_ack_o),
  .ld_valid_i   (ld_valid_i),
  .ld_addr_i    (ld_addr_i),
  .ld_stall_o   (ld_stall_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_data_o   (rsp_data_o),
  .arr_rd_en    (arr_rd_en),
  .byp_en       (byp_en)
);

// File: tb/l1_port_sched_tb.sv
module l1_port_sched_tb;
  localparam int NL = 8;
  localparam int AW = 9;
  localparam int LW = 512;
  localparam int HW = 256;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               fill_valid = 1'b0;
  logic [AW-1:0]      fill_addr = '0;
  logic [LW-1:0]      fill_data = '0;
  logic               fill_ack;
  logic [1:0]         ld_valid = '0;
  logic [1:0][AW-1:0] ld_addr = '0;
  logic [1:0]         ld_stall;
  logic [1:0]         rsp_valid;
  logic [1:0][HW-1:0] rsp_data;

  always #4 clk = ~clk;

  l1_port_sched #(.NUM_LINES(NL), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_data_i(fill_data),
    .fill_ack_o(fill_ack),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_stall_o(ld_stall),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [LW-1:0]      mem [NL];
  logic [1:0]         exp_v = '0;
  logic [1:0][HW-1:0] exp_d;
  logic [1:0]         exp_stall;
  logic [1:0]         exp_byp;
  string              rd_tag = "R6";

  function automatic logic [2:0] idx_of(input logic [AW-1:0] a);
    return a[8:6];
  endfunction

  function automatic logic [HW-1:0] half_of(input logic [LW-1:0] l, input logic h);
    return h ? l[LW-1:HW] : l[HW-1:0];
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int idx, input int h);
    logic [AW-1:0] a;
    a = '0;
    a[8:6] = 3'(idx);
    a[5] = h[0];
    return a;
  endfunction

  function automatic logic [LW-1:0] rnd_line();
    logic [LW-1:0] l;
    for (int i = 0; i < LW / 32; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [HW-1:0] act, input logic [HW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: check last responses, drive, check stalls, predict
  task automatic step(input bit fv, input logic [AW-1:0] fa, input logic [LW-1:0] fd,
                      input logic [1:0] lv, input logic [AW-1:0] la0,
                      input logic [AW-1:0] la1);
    logic [1:0][AW-1:0] la;
    logic [1:0] g;
    string tg;
    la[0] = la0;
    la[1] = la1;
    check(rsp_valid === exp_v, "R9", "rsp_valid", HW'(rsp_valid), HW'(exp_v));
    for (int p = 0; p < 2; p++)
      if (exp_v[p])
        check(rsp_data[p] === exp_d[p], exp_byp[p] ? "R4" : rd_tag, "rsp_data",
              rsp_data[p], exp_d[p]);
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    ld_valid = lv; ld_addr = la;
    #1;
    exp_byp = '0;
    if (fv) begin
      if (lv[0] && idx_of(la[0]) == idx_of(fa)) exp_byp[0] = 1'b1;
      else if (lv[1] && idx_of(la[1]) == idx_of(fa)) exp_byp[1] = 1'b1;
      g = exp_byp;
    end else begin
      g = lv;
    end
    exp_stall = lv & ~g;
    check(fill_ack === fv, "R2", "fill_ack", HW'(fill_ack), HW'(fv));
    for (int p = 0; p < 2; p++) begin
      if (!fv) tg = "R7";
      else if (lv[p] && idx_of(la[p]) == idx_of(fa) && !exp_byp[p]) tg = "R5";
      else if (lv[p] && idx_of(la[p]) != idx_of(fa)) tg = "R10";
      else tg = "R3";
      check(ld_stall[p] === exp_stall[p], tg, $sformatf("ld_stall[%0d]", p),
            HW'(ld_stall[p]), HW'(exp_stall[p]));
      exp_d[p] = exp_byp[p] ? half_of(fd, la[p][5]) : half_of(mem[idx_of(la[p])], la[p][5]);
    end
    exp_v = g;
    if (fv) mem[idx_of(fa)] = fd;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0]         hv;
    logic [1:0][AW-1:0] ha;
    logic [LW-1:0]      l;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(rsp_valid === 2'b00, "R1", "rsp_valid in reset", HW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 2'b00, "R1", "rsp_valid after reset", HW'(rsp_valid), '0);

    for (int i = 0; i < NL; i++) step(1'b1, mk_addr(i, 0), rnd_line(), 2'b00, '0, '0);

    // fill line 3 with both halves waiting: port 0 bypass, port 1 next cycle
    rd_tag = "R8";
    l = rnd_line();
    step(1'b1, mk_addr(3, 0), l, 2'b11, mk_addr(3, 0), mk_addr(3, 1));
    step(1'b0, '0, '0, 2'b10, '0, mk_addr(3, 1));
    step(1'b0, '0, '0, 2'b00, '0, '0);
    check(exp_v == 2'b00, "R8", "fill then both halves in two cycles", '0, '0);
    // port 1 alone matches the fill
    step(1'b1, mk_addr(5, 1), rnd_line(), 2'b11, mk_addr(2, 0), mk_addr(5, 1));
    step(1'b0, '0, '0, 2'b11, mk_addr(2, 0), mk_addr(5, 0));
    // neither matches
    rd_tag = "R6";
    step(1'b1, mk_addr(1, 0), rnd_line(), 2'b11, mk_addr(4, 1), mk_addr(6, 0));
    step(1'b0, '0, '0, 2'b11, mk_addr(4, 1), mk_addr(6, 0));
    // both ports same address, no fill
    step(1'b0, '0, '0, 2'b11, mk_addr(7, 1), mk_addr(7, 1));

    hv = '0;
    ha = '0;
    for (int c = 0; c < 3000; c++) begin
      bit fv;
      logic [AW-1:0] fa;
      for (int p = 0; p < 2; p++)
        if (!(hv[p] && exp_stall[p])) begin
          hv[p] = ($urandom % 10) < 7;
          ha[p] = mk_addr($urandom % NL, $urandom % 2);
        end
      fv = ($urandom % 10) < 4;
      if (($urandom % 2) == 0) fa = {ha[$urandom % 2][8:6], 6'd0};
      else fa = mk_addr($urandom % NL, 0);
      step(fv, fa, rnd_line(), hv, ha[0], ha[1]);
    end
    step(1'b0, '0, '0, 2'b00, '0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule